// File: doc/BRIEF.md
# Microcoded Multicycle Sequencer

This block drives the control points of a multicycle load/store datapath that shares one memory and one ALU across the steps of each instruction. It keeps a small control store of encoded 15-bit microwords and a micro-program counter. Each microword carries short codes for the ALU operation, the two ALU operand sources, the register write-back target, the memory access, the instruction register load, the program counter update and the next-address choice. A decode stage expands these codes into individual enables and multiplexer selects.

The next micro-address comes from one of three choices. It can be the following microword, a return to the fetch microword at address 0, or a jump through an opcode lookup table. The lookup table is used once per instruction, in the decode step. The datapath supplies only the 6-bit opcode and the ALU zero flag. The controller returns the control points, valid for the whole cycle of each microword. It also returns a combined program counter load strobe that already accounts for the branch condition.

Top module: `ucode_ctrl`

## Requirements
- R1: While rst_n is low, reg_write, mem_write, ir_write, pc_write, pc_write_cond and pc_load are 0 (also when reset is asserted in the middle of an instruction). After rst_n rises, these enables stay 0 for two clock edges. The fetch microword then presents its enables from the second rising edge until the third.
- R2: Fetch cycle: mem_read=1, i_or_d=0 (address from PC), ir_write=1, alu_sel_a=0 (PC), alu_sel_b=00 (constant 4), ext_sign=0, alu_op=00 (add), pc_write=1, pc_src=0 (ALU result), no register or memory write. The decode cycle follows: alu_op=00, alu_sel_a=0, alu_sel_b=10 (sign-extended offset shifted left by 2), ext_sign=1, and every enable 0.
- R3: Opcode 100011 (load): after decode come three cycles with alu_op=00, alu_sel_a=1 (register rs), alu_sel_b=11, ext_sign=1. The first has no enables. The second adds mem_read=1, i_or_d=1. The third adds reg_write=1, mem_to_reg=1, reg_dst=0. Fetch follows.
- R4: Opcode 101011 (store): two cycles with the same ALU settings as R3. The second adds mem_write=1, i_or_d=1. Fetch follows.
- R5: Opcode 000000 (register type): two cycles with alu_op=10 (function code), alu_sel_a=1, alu_sel_b=01 (register rt), ext_sign=0. The second adds reg_write=1, mem_to_reg=0, reg_dst=1. Fetch follows.
- R6: Opcode 001101 (OR immediate): two cycles with alu_op=11 (OR), alu_sel_a=1, alu_sel_b=11, ext_sign=0 (zero extension). The second adds reg_write=1, mem_to_reg=0, reg_dst=0. Fetch follows.
- R7: Opcode 000100 (branch on equal): one cycle with alu_op=01 (subtract), alu_sel_a=1, alu_sel_b=01, pc_write_cond=1, pc_src=1 (ALUout), pc_write=0. Fetch follows.
- R8: pc_load equals pc_write OR (pc_write_cond AND alu_zero) in the same cycle.
- R9: Any opcode other than the five above leads from decode straight back to fetch.
- R10: alu_zero affects no output other than pc_load. Outputs whose meaning is unused are driven 0: mem_to_reg and reg_dst when reg_write=0, i_or_d when no memory access, pc_src when no PC update, ext_sign when alu_sel_b is 00 or 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function code, 11 OR |
| alu_sel_a | output | 1 | First ALU operand: 0 PC, 1 register rs |
| alu_sel_b | output | 2 | Second operand: 00 const 4, 01 rt, 10 shifted extension, 11 extension |
| ext_sign | output | 1 | 1 sign extension, 0 zero extension |
| reg_write | output | 1 | Register file write enable |
| mem_to_reg | output | 1 | Write-back data: 0 ALUout, 1 memory data |
| reg_dst | output | 1 | Write-back target: 0 rt, 1 rd |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| i_or_d | output | 1 | Memory address: 0 PC, 1 ALUout |
| ir_write | output | 1 | Instruction register load |
| pc_write | output | 1 | Unconditional PC update |
| pc_write_cond | output | 1 | PC update taken only on zero |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALUout |
| pc_load | output | 1 | Resolved PC load strobe |

## Verification
The hardest case to reach is a reset that arrives partway through a multi-cycle instruction. After that reset, the enables must stay quiet through the synchronized release before fetch resumes. The stimulus runs a load, asserts rst_n during its memory-read step, and samples the enables asynchronously. It then counts edges after the release. Every one of the 64 opcodes is also driven with both zero-flag values, so the fallback dispatch and the zero gating of the PC strobe are covered on every path.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  localparam int UA_W = 4;

  typedef struct packed {
    logic [1:0] alu;
    logic       src1;
    logic [2:0] src2;
    logic [1:0] dest;
    logic [1:0] mem;
    logic       irw;
    logic [1:0] pcw;
    logic [1:0] seq;
  } uword_t;

  localparam logic [1:0] ALU_ADD = 2'b00;
  localparam logic [1:0] ALU_SUB = 2'b01;
  localparam logic [1:0] ALU_FN  = 2'b10;
  localparam logic [1:0] ALU_OR  = 2'b11;

  localparam logic [2:0] B_FOUR = 3'b000;
  localparam logic [2:0] B_RT   = 3'b001;
  localparam logic [2:0] B_SHF  = 3'b010;
  localparam logic [2:0] B_SEXT = 3'b011;
  localparam logic [2:0] B_ZEXT = 3'b100;

  localparam logic [1:0] WB_NONE  = 2'b00;
  localparam logic [1:0] WB_RD    = 2'b01;
  localparam logic [1:0] WB_RT    = 2'b10;
  localparam logic [1:0] WB_RTMEM = 2'b11;

  localparam logic [1:0] M_NONE = 2'b00;
  localparam logic [1:0] M_RDPC = 2'b01;
  localparam logic [1:0] M_RDAO = 2'b10;
  localparam logic [1:0] M_WRAO = 2'b11;

  localparam logic [1:0] P_NONE = 2'b00;
  localparam logic [1:0] P_ALU  = 2'b01;
  localparam logic [1:0] P_COND = 2'b10;

  localparam logic [1:0] N_SEQ   = 2'b00;
  localparam logic [1:0] N_FETCH = 2'b01;
  localparam logic [1:0] N_DISP  = 2'b10;

  localparam logic [UA_W-1:0] UA_FETCH = 4'd0;
  localparam logic [UA_W-1:0] UA_DEC   = 4'd1;
  localparam logic [UA_W-1:0] UA_LD    = 4'd2;
  localparam logic [UA_W-1:0] UA_ST    = 4'd5;
  localparam logic [UA_W-1:0] UA_RR    = 4'd7;
  localparam logic [UA_W-1:0] UA_ORI   = 4'd9;
  localparam logic [UA_W-1:0] UA_BR    = 4'd11;

endpackage

// File: rtl/ucode_rst_sync.sv
module ucode_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run = sync_q[STAGES-1];
endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch #(
  parameter int OPC_W = 6
) (
  input  logic [OPC_W-1:0]          opcode,
  output logic [ucode_pkg::UA_W-1:0] target
);
  import ucode_pkg::*;

  localparam logic [OPC_W-1:0] OP_RR  = OPC_W'(6'b000000);
  localparam logic [OPC_W-1:0] OP_LD  = OPC_W'(6'b100011);
  localparam logic [OPC_W-1:0] OP_ST  = OPC_W'(6'b101011);
  localparam logic [OPC_W-1:0] OP_ORI = OPC_W'(6'b001101);
  localparam logic [OPC_W-1:0] OP_BR  = OPC_W'(6'b000100);

  always_comb begin
    unique case (opcode)
      OP_RR:   target = UA_RR;
      OP_LD:   target = UA_LD;
      OP_ST:   target = UA_ST;
      OP_ORI:  target = UA_ORI;
      OP_BR:   target = UA_BR;
      default: target = UA_FETCH;
    endcase
  end
endmodule

// File: rtl/ucode_store.sv
module ucode_store (
  input  logic [ucode_pkg::UA_W-1:0] addr,
  output ucode_pkg::uword_t          word
);
  import ucode_pkg::*;

  always_comb begin
    case (addr)
      4'd0:  word = '{ALU_ADD, 1'b0, B_FOUR, WB_NONE,  M_RDPC, 1'b1, P_ALU,  N_SEQ};
      4'd1:  word = '{ALU_ADD, 1'b0, B_SHF,  WB_NONE,  M_NONE, 1'b0, P_NONE, N_DISP};
      4'd2:  word = '{ALU_ADD, 1'b1, B_SEXT, WB_NONE,  M_NONE, 1'b0, P_NONE, N_SEQ};
      4'd3:  word = '{ALU_ADD, 1'b1, B_SEXT, WB_NONE,  M_RDAO, 1'b0, P_NONE, N_SEQ};
      4'd4:  word = '{ALU_ADD, 1'b1, B_SEXT, WB_RTMEM, M_NONE, 1'b0, P_NONE, N_FETCH};
      4'd5:  word = '{ALU_ADD, 1'b1, B_SEXT, WB_NONE,  M_NONE, 1'b0, P_NONE, N_SEQ};
      4'd6:  word = '{ALU_ADD, 1'b1, B_SEXT, WB_NONE,  M_WRAO, 1'b0, P_NONE, N_FETCH};
      4'd7:  word = '{ALU_FN,  1'b1, B_RT,   WB_NONE,  M_NONE, 1'b0, P_NONE, N_SEQ};
      4'd8:  word = '{ALU_FN,  1'b1, B_RT,   WB_RD,    M_NONE, 1'b0, P_NONE, N_FETCH};
      4'd9:  word = '{ALU_OR,  1'b1, B_ZEXT, WB_NONE,  M_NONE, 1'b0, P_NONE, N_SEQ};
      4'd10: word = '{ALU_OR,  1'b1, B_ZEXT, WB_RT,    M_NONE, 1'b0, P_NONE, N_FETCH};
      4'd11: word = '{ALU_SUB, 1'b1, B_RT,   WB_NONE,  M_NONE, 1'b0, P_COND, N_FETCH};
      default: word = '{ALU_ADD, 1'b0, B_FOUR, WB_NONE, M_NONE, 1'b0, P_NONE, N_FETCH};
    endcase
  end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv_en,
  input  logic [1:0]                  seq_sel,
  input  logic [ucode_pkg::UA_W-1:0]  disp_addr,
  output logic [ucode_pkg::UA_W-1:0]  upc
);
  import ucode_pkg::*;

  logic [UA_W-1:0] upc_nxt;

  always_comb begin
    case (seq_sel)
      N_SEQ:   upc_nxt = upc + 1'b1;
      N_DISP:  upc_nxt = disp_addr;
      default: upc_nxt = UA_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upc <= UA_FETCH;
    else if (adv_en) upc <= upc_nxt;
  end
endmodule

// File: rtl/ucode_decode.sv
module ucode_decode (
  input  ucode_pkg::uword_t word,
  input  logic              wr_en,
  input  logic              alu_zero,
  output logic [1:0]        alu_op,
  output logic              alu_sel_a,
  output logic [1:0]        alu_sel_b,
  output logic              ext_sign,
  output logic              reg_write,
  output logic              mem_to_reg,
  output logic              reg_dst,
  output logic              mem_read,
  output logic              mem_write,
  output logic              i_or_d,
  output logic              ir_write,
  output logic              pc_write,
  output logic              pc_write_cond,
  output logic              pc_src,
  output logic              pc_load
);
  import ucode_pkg::*;

  logic rw_raw, mw_raw, pw_raw, pc_raw;

  assign alu_op    = word.alu;
  assign alu_sel_a = word.src1;

  always_comb begin
    case (word.src2)
      B_FOUR:  begin alu_sel_b = 2'b00; ext_sign = 1'b0; end
      B_RT:    begin alu_sel_b = 2'b01; ext_sign = 1'b0; end
      B_SHF:   begin alu_sel_b = 2'b10; ext_sign = 1'b1; end
      B_SEXT:  begin alu_sel_b = 2'b11; ext_sign = 1'b1; end
      default: begin alu_sel_b = 2'b11; ext_sign = 1'b0; end
    endcase
  end

  always_comb begin
    rw_raw = (word.dest != WB_NONE);
    mem_to_reg = (word.dest == WB_RTMEM);
    reg_dst    = (word.dest == WB_RD);
  end

  always_comb begin
    mem_read = (word.mem == M_RDPC) || (word.mem == M_RDAO);
    mw_raw   = (word.mem == M_WRAO);
    i_or_d   = (word.mem == M_RDAO) || (word.mem == M_WRAO);
  end

  always_comb begin
    pw_raw = (word.pcw == P_ALU);
    pc_raw = (word.pcw == P_COND);
    pc_src = pc_raw;
  end

  assign reg_write     = rw_raw & wr_en;
  assign mem_write     = mw_raw & wr_en;
  assign ir_write      = word.irw & wr_en;
  assign pc_write      = pw_raw & wr_en;
  assign pc_write_cond = pc_raw & wr_en;
  assign pc_load       = pc_write | (pc_write_cond & alu_zero);
endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl #(
  parameter int OPC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_zero,
  output logic [1:0]       alu_op,
  output logic             alu_sel_a,
  output logic [1:0]       alu_sel_b,
  output logic             ext_sign,
  output logic             reg_write,
  output logic             mem_to_reg,
  output logic             reg_dst,
  output logic             mem_read,
  output logic             mem_write,
  output logic             i_or_d,
  output logic             ir_write,
  output logic             pc_write,
  output logic             pc_write_cond,
  output logic             pc_src,
  output logic             pc_load
);
  import ucode_pkg::*;

  logic            run;
  logic [UA_W-1:0] upc;
  logic [UA_W-1:0] disp_addr;
  uword_t          word;

  ucode_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .run(run)
  );

  ucode_dispatch #(.OPC_W(OPC_W)) u_disp (
    .opcode(opcode), .target(disp_addr)
  );

  ucode_seq u_seq (
    .clk(clk), .rst_n(rst_n), .adv_en(run),
    .seq_sel(word.seq), .disp_addr(disp_addr), .upc(upc)
  );

  ucode_store u_store (
    .addr(upc), .word(word)
  );

  ucode_decode u_dec (
    .word(word), .wr_en(run), .alu_zero(alu_zero),
    .alu_op(alu_op), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
    .ext_sign(ext_sign), .reg_write(reg_write), .mem_to_reg(mem_to_reg),
    .reg_dst(reg_dst), .mem_read(mem_read), .mem_write(mem_write),
    .i_or_d(i_or_d), .ir_write(ir_write), .pc_write(pc_write),
    .pc_write_cond(pc_write_cond), .pc_src(pc_src), .pc_load(pc_load)
  );
endmodule

// File: rtl/ucode_ctrl_chk.sv
module ucode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alu_zero,
  input logic       reg_write,
  input logic       mem_to_reg,
  input logic       reg_dst,
  input logic       mem_read,
  input logic       mem_write,
  input logic       i_or_d,
  input logic       ir_write,
  input logic       pc_write,
  input logic       pc_write_cond,
  input logic       pc_src,
  input logic       pc_load
);
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> !(reg_write | mem_write | ir_write | pc_write | pc_write_cond | pc_load));

  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
    ir_write |=> !ir_write && !pc_write);

  a_r4_store_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write |-> i_or_d && !mem_read);

  a_r3_mem_wb_to_rt: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_write && mem_to_reg) |-> !reg_dst);

  a_r7_branch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    pc_write_cond |-> (pc_src && !pc_write));

  a_r8_cond_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !pc_write) |-> alu_zero);
endmodule

bind ucode_ctrl ucode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alu_zero(alu_zero),
  .reg_write(reg_write), .mem_to_reg(mem_to_reg), .reg_dst(reg_dst),
  .mem_read(mem_read), .mem_write(mem_write), .i_or_d(i_or_d),
  .ir_write(ir_write), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
  .pc_src(pc_src), .pc_load(pc_load)
);

// File: tb/test_ucode_ctrl.sv
`timescale 1ns/1ps
module test_ucode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic       alu_zero;
  logic [1:0] alu_op, alu_sel_b;
  logic alu_sel_a, ext_sign, reg_write, mem_to_reg, reg_dst, mem_read;
  logic mem_write, i_or_d, ir_write, pc_write, pc_write_cond, pc_src, pc_load;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ucode_ctrl i_ucode_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
    .alu_op(alu_op), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
    .ext_sign(ext_sign), .reg_write(reg_write), .mem_to_reg(mem_to_reg),
    .reg_dst(reg_dst), .mem_read(mem_read), .mem_write(mem_write),
    .i_or_d(i_or_d), .ir_write(ir_write), .pc_write(pc_write),
    .pc_write_cond(pc_write_cond), .pc_src(pc_src), .pc_load(pc_load)
  );

  // {alu_op, sel_a, sel_b, ext, rw, mtr, rdst, mrd, mwr, iod, irw, pcw, pcwc, pcsrc, pcload}
  function automatic logic [17:0] obs();
    return {alu_op, alu_sel_a, alu_sel_b, ext_sign, reg_write, mem_to_reg, reg_dst,
            mem_read, mem_write, i_or_d, ir_write, pc_write, pc_write_cond, pc_src, pc_load};
  endfunction

  function automatic logic [17:0] mk(logic [1:0] op, logic sa, logic [1:0] sb, logic ex,
      logic rw, logic mtr, logic rd, logic mr, logic mw, logic iod, logic irw,
      logic pw, logic pwc, logic ps, logic z);
    return {op, sa, sb, ex, rw, mtr, rd, mr, mw, iod, irw, pw, pwc, ps, (pw | (pwc & z))};
  endfunction

  localparam logic [17:0] WR_MASK = 18'b000000_100_010_1_1_1_0_1;

  task automatic chk(string req, logic [17:0] exp, logic [17:0] mask);
    logic [17:0] act = obs();
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act & mask, exp & mask);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_instr(logic [5:0] opc, logic z);
    logic [17:0] s;
    opcode = opc;
    alu_zero = z;
    chk("R2 fetch", mk(2'b00,0,2'b00,0, 0,0,0, 1,0,0, 1, 1,0,0, z), '1);
    step();
    chk("R2 decode", mk(2'b00,0,2'b10,1, 0,0,0, 0,0,0, 0, 0,0,0, z), '1);
    step();
    case (opc)
      6'b100011: begin
        s = mk(2'b00,1,2'b11,1, 0,0,0, 0,0,0, 0, 0,0,0, z);
        chk("R3 load addr", s, '1); step();
        chk("R3 load read", mk(2'b00,1,2'b11,1, 0,0,0, 1,0,1, 0, 0,0,0, z), '1); step();
        chk("R3 load wb", mk(2'b00,1,2'b11,1, 1,1,0, 0,0,0, 0, 0,0,0, z), '1); step();
      end
      6'b101011: begin
        chk("R4 store addr", mk(2'b00,1,2'b11,1, 0,0,0, 0,0,0, 0, 0,0,0, z), '1); step();
        chk("R4 store wr", mk(2'b00,1,2'b11,1, 0,0,0, 0,1,1, 0, 0,0,0, z), '1); step();
      end
      6'b000000: begin
        chk("R5 rr exec", mk(2'b10,1,2'b01,0, 0,0,0, 0,0,0, 0, 0,0,0, z), '1); step();
        chk("R5 rr wb", mk(2'b10,1,2'b01,0, 1,0,1, 0,0,0, 0, 0,0,0, z), '1); step();
      end
      6'b001101: begin
        chk("R6 ori exec", mk(2'b11,1,2'b11,0, 0,0,0, 0,0,0, 0, 0,0,0, z), '1); step();
        chk("R6 ori wb", mk(2'b11,1,2'b11,0, 1,0,0, 0,0,0, 0, 0,0,0, z), '1); step();
      end
      6'b000100: begin
        // R8: pc_load follows alu_zero in the branch cycle
        chk("R7 R8 branch", mk(2'b01,1,2'b01,0, 0,0,0, 0,0,0, 0, 0,1,1, z), '1); step();
      end
      default: ;  // R9: decode returns straight to fetch, checked by next call
    endcase
  endtask

  task automatic do_reset_release();
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 quiet edge1", '0, WR_MASK);
    step();
  endtask

  initial begin
    rst_n = 1'b0;
    opcode = '0;
    alu_zero = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", '0, WR_MASK);
    do_reset_release();
    // R9 R10: full sweep of opcodes and zero flag
    for (int z = 0; z < 2; z++)
      for (int o = 0; o < 64; o++)
        run_instr(6'(o), 1'(z));
    // R1: reset in the middle of a load memory read step
    opcode = 6'b100011;
    alu_zero = 1'b1;
    step(); step(); step();
    chk("R1 pre-reset load read", mk(2'b00,1,2'b11,1, 0,0,0, 1,0,1, 0, 0,0,0, 1), '1);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async quiet", '0, WR_MASK);
    do_reset_release();
    run_instr(6'b000100, 1'b1);
    run_instr(6'b000100, 1'b0);
    run_instr(6'b111111, 1'b1);
    chk("R9 back to fetch", mk(2'b00,0,2'b00,0, 0,0,0, 1,0,0, 1, 1,0,0, 1), '1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule